// File: doc/BRIEF.md
# Dual-Compare Timer/Counter

A 16-bit timer/counter with a count register, two compare limits (A and B) and a control register, all loaded through a simple write port. While enabled, it advances once per clock, or once per rising edge of an external event input when external counting is selected. When the count equals the active limit, the next advance returns the count to zero and raises a terminal event. That event drives the output waveform, an optional one-clock interrupt pulse and the stop decision in one-shot operation.

In single-limit operation only limit A is used, and the output gives a one-clock low pulse after each terminal event. In alternating operation the counter runs up to A, then up to B, then back to A. The output is high during the A phase and low during the B phase, so the two limits set the duty cycle. A read-only flag in the control readback shows which limit is active. The enable bit is guarded: a control write changes it only when the same write also sets a guard bit, and the guard bit is never stored. Software can use the block as a watchdog by reloading the count before it reaches the limit.

Top module: `dual_cmp_timer`

## Requirements
- R1: While enabled with internal counting, the count goes up by 1 on every clock edge that has no count write and no limit match. While disabled, the count does not change.
- R2: If the count equals the active limit when an advance is due, the count becomes 0 and a terminal event occurs. A limit of 0 therefore gives a terminal event on every advance.
- R3: In alternating mode (control bit 1 = 1), each terminal event swaps the active limit between A and B, starting with A. Control readback bit 12 is 1 while B is active. In single mode (bit 1 = 0) only A is used and bit 12 stays 0. Any control write clears bit 12.
- R4: With control bit 0 = 1 (continuous), the timer keeps running. With bit 0 = 0, it clears its enable bit (bit 15) at the end of a pass and the count stays at 0. A pass ends at the A terminal event in single mode and at the B terminal event in alternating mode.
- R5: A control write sets or clears enable (bit 15) only when bit 14 is 1 in that same write. Otherwise enable keeps its value. Bit 14 always reads back as 0.
- R6: With control bit 13 = 1, `irq_o` is high for one clock in the cycle after each terminal event. With bit 13 = 0, `irq_o` stays low.
- R7: In single mode, `tmr_out` is high, except for a one-clock low in the cycle after each terminal event.
- R8: In alternating mode, `tmr_out` is high while limit A is active and low while limit B is active.
- R9: A count write (`wr_sel` = 0) loads the count on that clock edge, overriding any advance, and causes no terminal event. Reloading more often than the limit period keeps `irq_o` from ever firing.
- R10: With control bit 2 = 1, the count advances once for each 0-to-1 transition of `ext_evt`. Each transition takes effect on the third clock edge after it is first sampled. A steady level does not advance the count.
- R11: After reset, the count, both limits and the control readback are 0, `tmr_out` is 1 and `irq_o` is 0.

Write select codes: 0 = count, 1 = limit A, 2 = limit B, 3 = control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_evt | input | 1 | External event input, asynchronous |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 count, 1 limit A, 2 limit B, 3 control |
| wr_data | input | 16 | Write data |
| cnt_o | output | 16 | Current count |
| ctrl_o | output | 16 | Control readback (bit 14 reads as 0, bit 12 shows the active limit) |
| tmr_out | output | 1 | Timer output waveform |
| irq_o | output | 1 | One-clock interrupt request |

## Verification
A wrong count shows up on `cnt_o` at the next clock. Because a terminal event is decided by comparing the count with the limit, the same error also shifts every later terminal event, the output edge and the interrupt pulse. A stale active-limit flag shows at once in readback bit 12. In alternating mode it also inverts `tmr_out` and makes the next pass use the wrong limit length. A bad enable or halt decision appears within one clock, as a count that keeps moving or freezes. The bench runs a behavioural model beside the design and compares every output on every clock, so any of these faults is caught in the cycle it first becomes visible.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int TW = 16;
  localparam int BIT_EN   = 15;
  localparam int BIT_GRD  = 14;
  localparam int BIT_INT  = 13;
  localparam int BIT_USEB = 12;
  localparam int BIT_EXT  = 2;
  localparam int BIT_ALT  = 1;
  localparam int BIT_CONT = 0;

  typedef enum logic [1:0] {
    SEL_CNT  = 2'd0,
    SEL_LIMA = 2'd1,
    SEL_LIMB = 2'd2,
    SEL_CTRL = 2'd3
  } dct_sel_e;

  function automatic logic cnt_hit(input logic [TW-1:0] c, input logic [TW-1:0] lim);
    return c == lim;
  endfunction

  function automatic logic [TW-1:0] cnt_step(input logic [TW-1:0] c, input logic hit);
    return hit ? '0 : c + TW'(1);
  endfunction

  function automatic logic pass_done(input logic alt, input logic useb);
    return alt ? useb : 1'b1;
  endfunction
endpackage

// File: rtl/dct_sync_edge.sv
module dct_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= async_in;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], async_in};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain[STAGES-1];

  assign rise = chain[STAGES-1] & ~last_q;

  // R10: one transition yields exactly one advance strobe
  a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/dct_core.sv
module dct_core
  import dct_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  input  logic [TW-1:0] lim_a,
  input  logic [TW-1:0] lim_b,
  input  logic          alt,
  input  logic          clr_useb,
  output logic [TW-1:0] cnt,
  output logic          useb,
  output logic          tc
);
  logic          hit;
  logic [TW-1:0] lim_act;

  assign lim_act = useb ? lim_b : lim_a;
  assign hit     = cnt_hit(cnt, lim_act);
  assign tc      = tick & hit & ~load;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (tick) cnt <= cnt_step(cnt, hit);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          useb <= 1'b0;
    else if (clr_useb)   useb <= 1'b0;
    else if (tc && alt)  useb <= ~useb;

  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && !hit) |=> cnt == $past(cnt) + TW'(1));
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt));
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> cnt == '0);
  a_r3_single_a_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!alt && !useb) |=> !useb);
  a_r9_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt == $past(load_val));
endmodule

// File: rtl/dct_out.sv
module dct_out (
  input  logic clk,
  input  logic rst_n,
  input  logic tc,
  input  logic int_en,
  input  logic alt,
  input  logic useb,
  output logic tmr_out,
  output logic irq
);
  logic pulse_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pulse_q <= 1'b0;
      irq     <= 1'b0;
    end else begin
      pulse_q <= tc;
      irq     <= tc & int_en;
    end

  assign tmr_out = alt ? ~useb : ~pulse_q;

  a_r6_irq_from_event: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(tc));
  a_r7_low_after_event: assert property (@(posedge clk) disable iff (!rst_n)
    (!alt && !tmr_out) |-> $past(tc));
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
  import dct_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_evt,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [TW-1:0] wr_data,
  output logic [TW-1:0] cnt_o,
  output logic [TW-1:0] ctrl_o,
  output logic          tmr_out,
  output logic          irq_o
);
  logic          en_q, int_q, ext_q, alt_q, cont_q;
  logic [TW-1:0] lim_a_q, lim_b_q;
  logic          wr_cnt, wr_lima, wr_limb, wr_ctrl;
  logic          ext_rise, tick, tc, useb, halt;

  assign wr_cnt  = wr_en && (wr_sel == SEL_CNT);
  assign wr_lima = wr_en && (wr_sel == SEL_LIMA);
  assign wr_limb = wr_en && (wr_sel == SEL_LIMB);
  assign wr_ctrl = wr_en && (wr_sel == SEL_CTRL);

  dct_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ext_evt), .rise(ext_rise)
  );

  assign tick = en_q & (ext_q ? ext_rise : 1'b1);

  dct_core u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(wr_cnt), .load_val(wr_data),
    .lim_a(lim_a_q), .lim_b(lim_b_q), .alt(alt_q), .clr_useb(wr_ctrl),
    .cnt(cnt_o), .useb(useb), .tc(tc)
  );

  assign halt = tc & ~cont_q & pass_done(alt_q, useb);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lim_a_q <= '0;
      lim_b_q <= '0;
    end else begin
      if (wr_lima) lim_a_q <= wr_data;
      if (wr_limb) lim_b_q <= wr_data;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q <= 1'b0; int_q <= 1'b0; ext_q <= 1'b0; alt_q <= 1'b0; cont_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        int_q  <= wr_data[BIT_INT];
        ext_q  <= wr_data[BIT_EXT];
        alt_q  <= wr_data[BIT_ALT];
        cont_q <= wr_data[BIT_CONT];
      end
      if (wr_ctrl && wr_data[BIT_GRD]) en_q <= wr_data[BIT_EN];
      else if (halt)                   en_q <= 1'b0;
    end

  always_comb begin
    ctrl_o           = '0;
    ctrl_o[BIT_EN]   = en_q;
    ctrl_o[BIT_INT]  = int_q;
    ctrl_o[BIT_USEB] = useb;
    ctrl_o[BIT_EXT]  = ext_q;
    ctrl_o[BIT_ALT]  = alt_q;
    ctrl_o[BIT_CONT] = cont_q;
  end

  dct_out u_out (
    .clk(clk), .rst_n(rst_n), .tc(tc), .int_en(int_q), .alt(alt_q),
    .useb(useb), .tmr_out(tmr_out), .irq(irq_o)
  );

  a_r4_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !(wr_ctrl && wr_data[BIT_GRD])) |=> !en_q);
  a_r5_guarded_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_ctrl && wr_data[BIT_GRD]) && !halt) |=> en_q == $past(en_q));
  a_r5_guard_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_o[BIT_GRD] == 1'b0);
endmodule

// File: tb/dual_cmp_timer_bench.sv
module dual_cmp_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_evt = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [15:0] cnt_o, ctrl_o;
  logic        tmr_out, irq_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit irq_seen = 0;

  dual_cmp_timer u_dual_cmp_timer (
    .clk(clk), .rst_n(rst_n), .ext_evt(ext_evt), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .cnt_o(cnt_o), .ctrl_o(ctrl_o), .tmr_out(tmr_out), .irq_o(irq_o)
  );

  always #5 clk = ~clk;

  // behavioural reference model
  logic [15:0] m_cnt, m_la, m_lb;
  bit m_en, m_int, m_ext, m_alt, m_cont, m_useb, m_pulse, m_irq;
  bit hist[3];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_la = 0; m_lb = 0;
      m_en = 0; m_int = 0; m_ext = 0; m_alt = 0; m_cont = 0;
      m_useb = 0; m_pulse = 0; m_irq = 0;
      hist[0] = 0; hist[1] = 0; hist[2] = 0;
    end else begin
      bit adv, match, ld, ev, nu, ne;
      logic [15:0] nc;
      adv   = m_en && (m_ext ? (hist[1] && !hist[2]) : 1'b1);
      match = (m_cnt == (m_useb ? m_lb : m_la));
      ld    = wr_en && wr_sel == 2'd0;
      ev    = adv && match && !ld;
      nc    = ld ? wr_data : (adv ? (match ? 16'd0 : m_cnt + 16'd1) : m_cnt);
      nu    = (ev && m_alt) ? !m_useb : m_useb;
      ne    = (ev && !m_cont && (!m_alt || m_useb)) ? 1'b0 : m_en;
      m_irq   = ev && m_int;
      m_pulse = ev;
      if (wr_en && wr_sel == 2'd3) begin
        m_int = wr_data[13]; m_ext = wr_data[2]; m_alt = wr_data[1]; m_cont = wr_data[0];
        nu = 0;
        if (wr_data[14]) ne = wr_data[15];
      end
      if (wr_en && wr_sel == 2'd1) m_la = wr_data;
      if (wr_en && wr_sel == 2'd2) m_lb = wr_data;
      m_cnt = nc; m_useb = nu; m_en = ne;
      hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = ext_evt;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (irq_o) irq_seen = 1;
      chk("R1 R2 R9 count vs model", cnt_o, m_cnt);
      chk("R3 R4 R5 control vs model", ctrl_o,
          {m_en, 1'b0, m_int, m_useb, 9'd0, m_ext, m_alt, m_cont});
      chk("R7 R8 output vs model", tmr_out, m_alt ? !m_useb : !m_pulse);
      chk("R6 irq vs model", irq_o, m_irq);
    end
    if (cycles > 100000) begin
      bad++;
      $display("FAIL watchdog expired actual=%0d expected<100000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    #1;
    chk("R11 reset count", cnt_o, 0);
    chk("R11 reset control", ctrl_o, 0);
    chk("R11 reset output", tmr_out, 1);
    chk("R11 reset irq", irq_o, 0);
    rst_n = 1;
    idle(2);
    chk("R1 disabled count holds", cnt_o, 0);

    // single, continuous, interrupts on, limit A = 3
    wr(2'd1, 16'd3);
    wr(2'd3, 16'hE001);
    idle(1);
    chk("R1 counting after enable", cnt_o, 1);
    begin
      int k = 0;
      while (tmr_out && k < 50) begin idle(1); k++; end
      chk("R7 low pulse seen", tmr_out, 0);
      chk("R2 count wrapped to zero", cnt_o, 0);
      chk("R6 irq with low pulse", irq_o, 1);
      idle(1);
      chk("R7 pulse lasts one clock", tmr_out, 1);
      chk("R3 single mode keeps A", ctrl_o[12], 0);
    end

    // unguarded disable attempt
    wr(2'd3, 16'h2001);
    idle(3);
    chk("R5 enable kept without guard", ctrl_o[15], 1);
    chk("R5 guard reads zero", ctrl_o[14], 0);
    // guarded disable
    wr(2'd3, 16'h4001);
    begin
      logic [15:0] held;
      held = cnt_o;
      idle(4);
      chk("R5 guarded disable took effect", ctrl_o[15], 0);
      chk("R1 disabled count frozen", cnt_o, held);
    end

    // limit 0: event on every advance, interrupts off
    wr(2'd0, 16'd0);
    wr(2'd1, 16'd0);
    irq_seen = 0;
    wr(2'd3, 16'hC001);
    idle(6);
    chk("R2 zero limit stays at zero", cnt_o, 0);
    chk("R6 no irq when disabled", irq_seen, 0);

    // alternating continuous A=2 B=4
    wr(2'd1, 16'd2);
    wr(2'd2, 16'd4);
    wr(2'd0, 16'd0);
    wr(2'd3, 16'hE003);
    begin
      int k = 0;
      while (!ctrl_o[12] && k < 50) begin idle(1); k++; end
      chk("R3 B becomes active", ctrl_o[12], 1);
      chk("R8 output low in B phase", tmr_out, 0);
      k = 0;
      while (ctrl_o[12] && k < 50) begin idle(1); k++; end
      chk("R8 output high in A phase", tmr_out, 1);
    end
    idle(30);

    // one-shot single A=5
    wr(2'd3, 16'h4000);
    wr(2'd1, 16'd5);
    wr(2'd0, 16'd0);
    wr(2'd3, 16'hC000);
    idle(14);
    chk("R4 one-shot single cleared enable", ctrl_o[15], 0);
    chk("R4 one-shot single count rests", cnt_o, 0);

    // one-shot alternating A=1 B=1
    wr(2'd1, 16'd1);
    wr(2'd2, 16'd1);
    wr(2'd0, 16'd0);
    wr(2'd3, 16'hC002);
    idle(12);
    chk("R4 one-shot alternating stopped after B", ctrl_o[15], 0);
    chk("R3 flag back to A after pass", ctrl_o[12], 0);

    // reload as watchdog: A=10, reload every 5 clocks
    wr(2'd1, 16'd10);
    wr(2'd0, 16'd0);
    irq_seen = 0;
    wr(2'd3, 16'hE001);
    for (int i = 0; i < 8; i++) begin
      idle(3);
      wr(2'd0, 16'd0);
    end
    chk("R9 reloads suppress irq", irq_seen, 0);
    wr(2'd0, 16'h0007);
    idle(1);
    chk("R9 loaded value visible", cnt_o, 8);

    // external counting
    wr(2'd3, 16'h4000);
    wr(2'd1, 16'd100);
    wr(2'd0, 16'd0);
    wr(2'd3, 16'hC005);
    for (int i = 0; i < 4; i++) begin
      ext_evt = 1; idle(3);
      ext_evt = 0; idle(3);
    end
    idle(4);
    chk("R10 one advance per rising edge", cnt_o, 4);
    ext_evt = 1;
    idle(12);
    chk("R10 steady high gives one advance", cnt_o, 5);

    idle(5);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule